// File: doc/BRIEF.md
# Edge-Selectable External Interrupt with Sleep Wake

This block serves one external interrupt pin of a small microcontroller. The pin first passes through a two-flop synchroniser. A polarity bit set by software then picks whether a rising or a falling transition counts as an event. Each selected event sets a sticky flag, which stays set until software clears it. The interrupt request is the flag gated by a local enable. The request is updated only on the boundary of a four-tick instruction cycle, which gives the core a response window of three to four instruction cycles.

While the core is asleep, an event produces a one-cycle wake pulse. This happens only if the local enable was set just before sleep began. Alongside the wake pulse the block reports where the woken core should go: to the interrupt vector (address 0x0004) when the global enable is set, or on to the next instruction when it is clear. When the pin is configured as analog, its digital value is forced low, so it produces no events.

Top module: `ext_irq_edge`

## Requirements
- R1: After reset, flag_o, irq_req_o, wake_o and wake_vec_o are all 0.
- R2: With rise_sel_i=1 a 0-to-1 pin change sets flag_o, and with rise_sel_i=0 a 1-to-0 change sets it; the other direction does not. flag_o first reads 1 exactly three rising clock edges after the pin change is applied.
- R3: The flag records events whatever the values of irq_en_i and gie_i.
- R4: flag_clr_i clears flag_o on the next clock edge; an event detected in the same cycle wins and the flag stays 1. The flag never clears without the strobe.
- R5: irq_req_o loads flag_o AND irq_en_i only on clock edges where the tick counter (cleared by reset, +1 per edge, modulo 4) reads 3; between those edges it holds. A request persists while the flag is uncleared.
- R6: Changing rise_sel_i while the pin is steady never sets the flag.
- R7: While analog_i=1 the pin is read as 0, so pin toggles set no flag.
- R8: wake_o pulses for one cycle, on the same edge that sets the flag, for an event while sleep_i=1. It does so only if irq_en_i was 1 in the cycle before sleep_i rose; changing irq_en_i during sleep has no effect, and wake_o stays 0 when not asleep.
- R9: wake_vec_o is 1 with a wake pulse when gie_i was 1 in the detection cycle (branch to 0x0004), else 0 (resume the next instruction); it is never 1 without wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four ticks per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external pin |
| analog_i | input | 1 | Pin configured analog; digital value reads 0 |
| rise_sel_i | input | 1 | 1 = rising events, 0 = falling events |
| irq_en_i | input | 1 | Local interrupt enable |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| sleep_i | input | 1 | Core is asleep |
| gie_i | input | 1 | Global interrupt enable |
| flag_o | output | 1 | Sticky event flag |
| irq_req_o | output | 1 | Interrupt request, updated at cycle boundaries |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_vec_o | output | 1 | With wake_o: 1 = vector, 0 = resume |

## Verification
A sweep applies a rising pulse and then a falling pulse under every combination of polarity, local enable, global enable, sleep state and analog setting. Each pulse starts at each of the four tick phases. Enabled runs separate the correct edge from the wrong one. Sleep runs separate the enable captured before sleep from the value flipped during sleep. The phase offsets separate loading the request at a cycle boundary from loading it on every edge. Directed cases pin down the exact three-edge flag latency, a clear that collides with an event, and polarity flips on a steady pin.

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int SYNC_LEN = 2,
  parameter int TICKS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic analog_i,
  input  logic rise_sel_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  input  logic sleep_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_req_o,
  output logic wake_o,
  output logic wake_vec_o
);
  localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [SYNC_LEN:0] shr;
  logic [PW-1:0]     ph;
  logic              armed;
  logic              pin_d, rise, fall, hit;

  assign pin_d = pin_i & ~analog_i;
  assign rise  = shr[SYNC_LEN-1] & ~shr[SYNC_LEN];
  assign fall  = ~shr[SYNC_LEN-1] & shr[SYNC_LEN];
  assign hit   = rise_sel_i ? rise : fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC_LEN-1:0], pin_d};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          flag_o <= 1'b0;
    else if (hit)        flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          irq_req_o <= 1'b0;
    else if (ph == LAST) irq_req_o <= flag_o & irq_en_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        armed <= 1'b0;
    else if (!sleep_i) armed <= irq_en_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_o     <= 1'b0;
      wake_vec_o <= 1'b0;
    end else begin
      wake_o     <= sleep_i & armed & hit;
      wake_vec_o <= sleep_i & armed & hit & gie_i;
    end

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sleep_i)); // R8
  AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> flag_o); // R8
  AST_FLAG_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_clr_i)); // R4
  AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_req_o) |-> $past(ph) == LAST); // R5
  AST_VEC_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vec_o |-> wake_o); // R9
endmodule

// File: tb/test_ext_irq_edge.sv
`timescale 1ns/1ps
module test_ext_irq_edge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 0, ana = 0, pol = 0, en = 0, clr = 0, slp = 0, gie = 0;
  logic flag, req, wake, vec;
  int nvec = 0, nbad = 0, ncyc = 0;

  always #2.5 clk = ~clk;

  ext_irq_edge i_ext_irq_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .analog_i(ana), .rise_sel_i(pol),
    .irq_en_i(en), .flag_clr_i(clr), .sleep_i(slp), .gie_i(gie),
    .flag_o(flag), .irq_req_o(req), .wake_o(wake), .wake_vec_o(vec));

  // expectation built from the requirement text, cycle by cycle
  logic e_a, e_b, e_c, e_flag, e_req, e_arm, e_wake, e_vec;
  int   e_tick;
  logic ev;
  always_comb ev = pol ? (e_b & ~e_c) : (~e_b & e_c);
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {e_a, e_b, e_c, e_flag, e_req, e_arm, e_wake, e_vec} <= '0;
      e_tick <= 0;
    end else begin
      e_a <= pin & ~ana; e_b <= e_a; e_c <= e_b;
      e_flag <= ev ? 1'b1 : (clr ? 1'b0 : e_flag);
      if (e_tick % 4 == 3) e_req <= e_flag & en;
      e_tick <= e_tick + 1;
      if (!slp) e_arm <= en;
      e_wake <= slp & e_arm & ev;
      e_vec  <= slp & e_arm & ev & gie;
    end

  task automatic chk(input logic act, input logic exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, ncyc);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; ncyc++;
    chk(flag, e_flag, "R2 flag");
    chk(req,  e_req,  "R5 irq_req");
    chk(wake, e_wake, "R8 wake");
    chk(vec,  e_vec,  "R9 wake_vec");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_flag();
    clr = 1; tick(); clr = 0; tick();
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(flag, 1'b0, "R1 reset flag"); chk(req, 1'b0, "R1 reset req");
    chk(wake, 1'b0, "R1 reset wake"); chk(vec, 1'b0, "R1 reset vec");
    rst_n = 1;
    ticks(4);

    // R2 latency: exactly three edges from pin change to flag
    pol = 1; pin = 1;
    tick(); tick(); chk(flag, 1'b0, "R2 flag before 3 edges");
    tick();         chk(flag, 1'b1, "R2 flag at 3 edges");
    ticks(4); clear_flag();

    // R6: polarity flips with steady pin
    for (int k = 0; k < 4; k++) begin pol = ~pol; tick(); end
    ticks(4); chk(flag, 1'b0, "R6 polarity flip no event");
    pin = 0; pol = 0; ticks(6); clear_flag(); ticks(2);

    // R3: enables low still record
    en = 0; gie = 0; pol = 1; pin = 1; ticks(5);
    chk(flag, 1'b1, "R3 flag with enables low");
    chk(req,  1'b0, "R3 no request when disabled");
    // R4: clear colliding with an event keeps flag
    pol = 0; pin = 0; tick(); tick(); clr = 1; tick(); clr = 0;
    chk(flag, 1'b1, "R4 event wins over clear");
    clear_flag(); chk(flag, 1'b0, "R4 clear alone");

    // R7: analog input hides pin
    ana = 1; pol = 1; pin = 1; ticks(5); pin = 0; ticks(5);
    chk(flag, 1'b0, "R7 analog no event"); ana = 0; ticks(4);

    // sweep
    for (int c = 0; c < 32; c++)
      for (int ofs = 0; ofs < 4; ofs++) begin
        pin = 0; slp = 0; clr = 0;
        pol = c[0]; en = c[1]; gie = c[2]; ana = c[4];
        ticks(4 + ofs);
        if (c[3]) begin slp = 1; tick(); en = ~en; end
        pin = 1; ticks(7);
        pin = 0; ticks(7);
        slp = 0; ana = 0;
        clear_flag(); ticks(8);
      end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule